// File: doc/BRIEF.md
# Polyphase Modulo-PCM Pixel Encoder

This block shrinks 8-bit grayscale pixels by discarding bits, taking sixteen pixels from two 64-bit buffer read ports in one clock cycle. Each pixel's row and column parity place it in one of four polyphase sets. The set at an even row and even column is coded as plain PCM: its low bits are dropped. The other three sets are coded modulo: both low and high bits are dropped. A decoder later rebuilds the lost high bits from neighbouring PCM pixels. The number of cycles a frame takes depends only on the image size, never on pixel content.

One beat carries sixteen horizontally adjacent pixels of a single row. The first beat of a row always starts at an even column. The block counts beats to track which row it is on. The first beat of a frame is flagged, and the three coding parameters are captured on that beat. Each output beat carries sixteen right-aligned coded words, each with a 2-bit phase tag, under one valid flag. A downstream stall holds the input stream.

Top module: `mpcm_pixel_coder`

## Requirements
- R1: Lane i takes its pixel from `in_pix_a[8i+7:8i]` for i<8 and from `in_pix_b[8(i-8)+7:8(i-8)]` for i≥8. Its result is on `out_code[8i+7:8i]` and its phase tag is on `out_phase[2i+1:2i]`. In the tag, bit 1 is the row parity and bit 0 is the column parity, which equals i mod 2.
- R2: A lane tagged 00 carries the pixel shifted right by the effective drop-low count of the PCM set (pixel >> l0).
- R3: A lane with any other tag carries (pixel >> lk) mod 2^(8−lk−mk). Its upper bits are zero.
- R4: The row parity is 0 on a beat flagged `in_sof`. It toggles after every IMG_WIDTH/16 accepted beats.
- R5: `cfg_l0`, `cfg_lk` and `cfg_mk` are captured only on an accepted `in_sof` beat. That beat already uses the new values. Changes at any other time have no effect until the next frame start.
- R6: If the captured l0 exceeds lk, l0 is reduced to lk.
- R7: If lk+mk exceeds 7, mk is reduced to 7−lk, so at least one bit survives on the modulo sets.
- R8: An accepted beat (`in_valid` and `in_ready`) appears on the output on the next clock. `in_ready` is high whenever the output is empty or is being taken.
- R9: While `out_valid` is high and `out_ready` is low, the output beat holds unchanged and `in_ready` is low. No beat is dropped or duplicated.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_l0 | input | 3 | Low bits dropped on the PCM set |
| cfg_lk | input | 3 | Low bits dropped on the modulo sets |
| cfg_mk | input | 3 | High bits dropped on the modulo sets |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_sof | input | 1 | Beat is the first of a frame |
| in_pix_a | input | 64 | Pixels of lanes 0 to 7 |
| in_pix_b | input | 64 | Pixels of lanes 8 to 15 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_sof | output | 1 | Output beat is the first of a frame |
| out_code | output | 128 | Sixteen right-aligned coded words |
| out_phase | output | 32 | Sixteen phase tags |

## Verification
Two events can fall in the same cycle. A stalled output beat can be released while the next input beat is taken, and a frame-start beat can arrive while the old parameters still govern the beat in the output register. The bench holds a beat back with `out_ready` low and queues a second beat. It then raises `out_ready` and checks that the second beat follows the first exactly once. It also changes the configuration in the middle of a frame and on a frame-start beat, then compares every lane against codes computed from the parameters that should apply to that beat.

// File: rtl/mpcm_pixel_coder.sv
module mpcm_pixel_coder #(
  parameter int IMG_WIDTH      = 64,
  parameter int PIX_BITS       = 8,
  parameter int LANES_PER_PORT = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [$clog2(PIX_BITS)-1:0]          cfg_l0,
  input  logic [$clog2(PIX_BITS)-1:0]          cfg_lk,
  input  logic [$clog2(PIX_BITS)-1:0]          cfg_mk,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic                                 in_sof,
  input  logic [LANES_PER_PORT*PIX_BITS-1:0]   in_pix_a,
  input  logic [LANES_PER_PORT*PIX_BITS-1:0]   in_pix_b,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic                                 out_sof,
  output logic [2*LANES_PER_PORT*PIX_BITS-1:0] out_code,
  output logic [4*LANES_PER_PORT-1:0]          out_phase
);
  localparam int LANES = 2 * LANES_PER_PORT;
  localparam int PW    = $clog2(PIX_BITS);
  localparam int BPR   = IMG_WIDTH / LANES;
  localparam int BW    = (BPR > 1) ? $clog2(BPR) : 1;
  localparam logic [PW:0] MAXKEEP = PIX_BITS - 1;

  logic [PW-1:0] l0_q, lk_q, mk_q;
  logic [PW-1:0] l0_e, lk_e, mk_e, l0_c, mk_c;
  logic [BW-1:0] beat_q, beat_cur;
  logic          row_q, row_cur;
  logic          take;
  logic [LANES*PIX_BITS-1:0] code_d;
  logic [2*LANES-1:0]        phase_d;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  assign l0_c = (cfg_l0 > cfg_lk) ? cfg_lk : cfg_l0;
  assign mk_c = ({1'b0, cfg_lk} + {1'b0, cfg_mk} > MAXKEEP) ? PW'(MAXKEEP - {1'b0, cfg_lk}) : cfg_mk;

  assign l0_e = in_sof ? l0_c   : l0_q;
  assign lk_e = in_sof ? cfg_lk : lk_q;
  assign mk_e = in_sof ? mk_c   : mk_q;

  assign beat_cur = in_sof ? '0   : beat_q;
  assign row_cur  = in_sof ? 1'b0 : row_q;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [PIX_BITS-1:0] pix, keep_mask;
      if (i < LANES_PER_PORT) begin : g_a
        assign pix = in_pix_a[i*PIX_BITS +: PIX_BITS];
      end else begin : g_b
        assign pix = in_pix_b[(i-LANES_PER_PORT)*PIX_BITS +: PIX_BITS];
      end
      assign keep_mask = {PIX_BITS{1'b1}} >> ({1'b0, lk_e} + {1'b0, mk_e});
      assign phase_d[2*i +: 2] = {row_cur, 1'(i % 2)};
      assign code_d[i*PIX_BITS +: PIX_BITS] = (row_cur || (i % 2 == 1)) ?
             ((pix >> lk_e) & keep_mask) : (pix >> l0_e);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l0_q <= '0; lk_q <= '0; mk_q <= '0;
      beat_q <= '0; row_q <= 1'b0;
      out_valid <= 1'b0; out_sof <= 1'b0;
      out_code <= '0; out_phase <= '0;
    end else begin
      if (take) begin
        l0_q <= l0_e; lk_q <= lk_e; mk_q <= mk_e;
        if (beat_cur == BW'(BPR - 1)) begin
          beat_q <= '0;
          row_q  <= !row_cur;
        end else begin
          beat_q <= beat_cur + 1'b1;
          row_q  <= row_cur;
        end
        out_valid <= 1'b1;
        out_sof   <= in_sof;
        out_code  <= code_d;
        out_phase <= phase_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module mpcm_pixel_coder_chk #(
  parameter int PIX_BITS = 8,
  parameter int LANES    = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [LANES*PIX_BITS-1:0] out_code,
  input logic [2*LANES-1:0]        out_phase,
  input logic                      out_sof,
  input logic [$clog2(PIX_BITS)-1:0] l0_q,
  input logic [$clog2(PIX_BITS)-1:0] lk_q,
  input logic [$clog2(PIX_BITS)-1:0] mk_q
);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_phase) && $stable(out_sof));
  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r6_l0_not_above_lk: assert property (@(posedge clk) disable iff (!rst_n)
    l0_q <= lk_q);
  a_r7_one_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lk_q) + int'(mk_q) <= PIX_BITS - 1);

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_chk
      a_r1_col_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_phase[2*i] == 1'(i % 2));
      a_r4_sof_row_even: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sof |-> out_phase[2*i+1] == 1'b0);
      a_r3_mod_width: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_phase[2*i +: 2] != 2'b00 |->
        (out_code[i*PIX_BITS +: PIX_BITS] >> (PIX_BITS - int'(lk_q) - int'(mk_q))) == '0);
    end
  endgenerate
endmodule

bind mpcm_pixel_coder mpcm_pixel_coder_chk #(.PIX_BITS(PIX_BITS), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .out_phase(out_phase), .out_sof(out_sof), .l0_q(l0_q), .lk_q(lk_q), .mk_q(mk_q));

// File: tb/mpcm_pixel_coder_tb.sv
module mpcm_pixel_coder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IMG_W = 64;
  localparam int BPR = IMG_W / 16;

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_l0 = 0, cfg_lk = 0, cfg_mk = 0;
  logic in_valid = 0, in_sof = 0, out_ready = 1;
  logic [63:0] in_pix_a = 0, in_pix_b = 0;
  logic in_ready, out_valid, out_sof;
  logic [127:0] out_code;
  logic [31:0] out_phase;

  int n_chk = 0, n_bad = 0;
  int m_l0 = 0, m_lk = 0, m_mk = 0, m_beat = 0, m_row = 0;
  logic [127:0] e_code;
  logic [31:0] e_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpcm_pixel_coder #(.IMG_WIDTH(IMG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_l0(cfg_l0), .cfg_lk(cfg_lk), .cfg_mk(cfg_mk),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_pix_a(in_pix_a), .in_pix_b(in_pix_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_code(out_code), .out_phase(out_phase));

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model: R1..R7 from requirements
  task automatic model_beat(input logic sof, input logic [63:0] a, input logic [63:0] b);
    if (sof) begin
      m_lk = cfg_lk;
      m_l0 = (cfg_l0 > cfg_lk) ? cfg_lk : cfg_l0;
      m_mk = (cfg_lk + cfg_mk > 7) ? 7 - cfg_lk : cfg_mk;
      m_beat = 0; m_row = 0;
    end
    for (int i = 0; i < 16; i++) begin
      logic [7:0] p;
      logic [1:0] t;
      p = (i < 8) ? a[8*i +: 8] : b[8*(i-8) +: 8];
      t = {1'(m_row), 1'(i % 2)};
      e_phase[2*i +: 2] = t;
      e_code[8*i +: 8] = (t == 2'b00) ? (p >> m_l0) : ((p >> m_lk) & (8'hFF >> (m_lk + m_mk)));
    end
    m_beat++;
    if (m_beat == BPR) begin m_beat = 0; m_row ^= 1; end
  endtask

  task automatic send(input string req, input logic sof);
    logic [63:0] a, b;
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_pix_a = a; in_pix_b = b;
    model_beat(sof, a, b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    check(req, {out_valid, out_sof, out_phase, out_code}, {1'b1, sof, e_phase, e_code});
  endtask

  task automatic t_reset;
    check("R10 reset", {out_valid, in_ready}, {1'b0, 1'b1});
  endtask

  task automatic t_frame(input int l0, input int lk, input int mk, input int beats);
    @(negedge clk); cfg_l0 = 3'(l0); cfg_lk = 3'(lk); cfg_mk = 3'(mk);
    send("R1 R2 R3 R4 frame start", 1'b1);
    for (int k = 1; k < beats; k++) send("R1 R2 R3 R4 beat", 1'b0);
  endtask

  task automatic t_midframe_cfg;
    @(negedge clk); cfg_l0 = 3; cfg_lk = 3; cfg_mk = 0;
    send("R5 sof capture", 1'b1);
    @(negedge clk); cfg_l0 = 0; cfg_lk = 1; cfg_mk = 2;
    for (int k = 0; k < 5; k++) send("R5 mid-frame change ignored", 1'b0);
  endtask

  task automatic t_clamps;
    @(negedge clk); cfg_l0 = 5; cfg_lk = 2; cfg_mk = 1;
    send("R6 l0 clamp", 1'b1);
    send("R6 l0 clamp odd row", 1'b0);
    @(negedge clk); cfg_l0 = 1; cfg_lk = 6; cfg_mk = 4;
    send("R7 mk clamp", 1'b1);
    for (int k = 0; k < BPR; k++) send("R7 mk clamp rows", 1'b0);
  endtask

  task automatic t_sof_midrow;
    @(negedge clk); cfg_l0 = 2; cfg_lk = 4; cfg_mk = 0;
    send("R4 first", 1'b1);
    send("R4 second", 1'b0);
    send("R4 restart mid-row", 1'b1);
    for (int k = 0; k < BPR; k++) send("R4 after restart", 1'b0);
  endtask

  task automatic t_stall;
    logic [127:0] c1; logic [31:0] p1;
    logic [63:0] a, b;
    @(negedge clk); out_ready = 0;
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    in_valid = 1; in_sof = 0; in_pix_a = a; in_pix_b = b;
    model_beat(1'b0, a, b); c1 = e_code; p1 = e_phase;
    @(posedge clk); @(negedge clk);
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    in_pix_a = a; in_pix_b = b;
    for (int k = 0; k < 3; k++) begin
      check("R9 held beat", {in_ready, out_valid, out_phase, out_code}, {1'b0, 1'b1, p1, c1});
      @(negedge clk);
    end
    model_beat(1'b0, a, b);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check("R8 R9 release and take", {out_valid, out_phase, out_code}, {1'b1, e_phase, e_code});
    @(negedge clk);
    check("R9 no duplicate", {159'b0, out_valid}, 160'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_frame(1, 4, 1, 2*BPR + 1);
    t_frame(2, 2, 0, BPR + 2);
    t_frame(0, 0, 7, 3);
    t_midframe_cfg;
    t_clamps;
    t_sof_midrow;
    t_stall;
    t_frame(1, 3, 0, 2*BPR);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule